// File: doc/BRIEF.md
# Sliding-Window Tower Distributor

This block feeds eight feature-extraction cores from one bunch crossing's grid of calorimeter tower words. The grid is 6 eta columns by 10 phi rows. A one-cycle load strobe copies the whole grid into a column-wide shift register in one step. On each following fast clock the register moves down by one eta column. Only the three lowest register columns are tapped. A column therefore enters the window at the top as environment, becomes the core, and leaves through the bottom as environment before it is dropped.

Each core k stays on phi row k+1 and sees a 3x3 window made of rows k..k+2 across register locations 0..2. One step of the sequence moves every core one eta step higher. One extra register column sits above the highest input column and is loaded with zeros. Zeros also enter behind the data while it shifts. Together these give five distinct windows, tagged with a 0..4 index. A board on the edge of the detector sets a border flag and a side flag, and the block then zeroes the eta column that the calorimeter does not supply.

Top module: `tower_window_shifter`

## Requirements
- R1: While reset is held and on the cycle after it is released, `win_valid` is 0 and every window word is zero.
- R2: On the cycle after `bc_load` is high, `win_valid` is 1 and `win_step` is 0. Word index i = (k*3 + loc)*3 + d of `win_out` (bits i*W +: W) then holds the tower at column loc, row k+d. Tower (c, r) is read from `towers_in[(10*c + r)*W +: W]`.
- R3: On each later cycle without `bc_load`, `win_step` advances by one and location loc shows column `win_step`+loc. Values on `towers_in` during these cycles have no effect.
- R4: A location that refers to a column at or beyond index 6 reads as zero. At step 4, location 2 is zero.
- R5: After step 4, with no new strobe, `win_valid` falls to 0 on the next cycle.
- R6: If `border_en`=1 and `border_high`=0 when the strobe is high, column 0 is loaded as zeros.
- R7: If `border_en`=1 and `border_high`=1 when the strobe is high, column 5 is loaded as zeros.
- R8: If `border_en`=0, all six columns are loaded unchanged, whatever the value of `border_high`.
- R9: A strobe that arrives part-way through a sequence reloads the grid and restarts at step 0 with the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous reset, active high |
| bc_load | input | 1 | Bunch-crossing strobe; loads the grid in parallel |
| border_en | input | 1 | Board sits on a detector eta edge |
| border_high | input | 1 | Edge side: 1 = high eta, 0 = low eta |
| towers_in | input | 60*W | Tower grid, tower 10*c+r at bits (10*c+r)*W +: W |
| win_out | output | 8*9*W | Per-core 3x3 windows, index (k*3+loc)*3+d |
| win_valid | output | 1 | A window is being presented |
| win_step | output | 3 | Window index 0..4 within the crossing |

## Verification
Each tower gets a distinct nonzero value derived from a per-crossing seed. A stuck, swapped or mis-shifted word therefore shows up as a wrong value, not as a coincidental match. Four crossing patterns are used. With no border and the side flag set, the run shows that the side flag alone changes nothing. A low-edge crossing and a high-edge crossing show that the correct column, and only that column, is zeroed. A strobe part-way through a sequence checks that the step index restarts and old data is replaced. Between strobes the input bus carries unrelated values, which shows that shifting ignores the input. A gap after step 4 exposes the drop of the valid flag.

// File: rtl/tower_window_shifter.sv
module tower_window_shifter #(
  parameter int W    = 10,
  parameter int NCOL = 6,
  parameter int NROW = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bc_load,
  input  logic                         border_en,
  input  logic                         border_high,
  input  logic [NCOL*NROW*W-1:0]       towers_in,
  output logic [(NROW-2)*9*W-1:0]      win_out,
  output logic                         win_valid,
  output logic [2:0]                   win_step
);
  localparam int NCORE = NROW - 2;
  localparam int LAST  = NCOL - 2;

  logic [W-1:0] sr [NCOL+1][NROW];
  logic lo_kill, hi_kill;

  assign lo_kill = border_en & ~border_high;
  assign hi_kill = border_en &  border_high;

  for (genvar c = 0; c <= NCOL; c++) begin : g_col
    for (genvar r = 0; r < NROW; r++) begin : g_row
      if (c < NCOL) begin : g_data
        logic kill;
        if (c == 0) begin : g_lo
          assign kill = lo_kill;
        end else if (c == NCOL-1) begin : g_hi
          assign kill = hi_kill;
        end else begin : g_mid
          assign kill = 1'b0;
        end
        always_ff @(posedge clk) begin
          if (rst)          sr[c][r] <= '0;
          else if (bc_load) sr[c][r] <= kill ? '0 : towers_in[(NROW*c+r)*W +: W];
          else              sr[c][r] <= sr[c+1][r];
        end
        if (c < NCOL-1) begin : g_chk
          assert_shift_down_R3: assert property (@(posedge clk) disable iff (rst)
            !bc_load |=> sr[c][r] == $past(sr[c+1][r]));
        end
      end else begin : g_pad
        always_ff @(posedge clk) sr[c][r] <= '0;
      end
    end
  end

  for (genvar k = 0; k < NCORE; k++) begin : g_core
    for (genvar l = 0; l < 3; l++) begin : g_loc
      for (genvar d = 0; d < 3; d++) begin : g_dr
        assign win_out[((k*3+l)*3+d)*W +: W] = sr[l][k+d];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_valid <= 1'b0;
      win_step  <= '0;
    end else if (bc_load) begin
      win_valid <= 1'b1;
      win_step  <= '0;
    end else if (win_valid) begin
      if (win_step == 3'(LAST)) begin
        win_valid <= 1'b0;
        win_step  <= '0;
      end else begin
        win_step <= win_step + 3'd1;
      end
    end
  end

  assert_load_start_R2: assert property (@(posedge clk) disable iff (rst)
    bc_load |=> win_valid && win_step == 3'd0);
  assert_step_adv_R3: assert property (@(posedge clk) disable iff (rst)
    win_valid && win_step != 3'(LAST) && !bc_load |=> win_valid && win_step == $past(win_step) + 3'd1);
  assert_end_drop_R5: assert property (@(posedge clk) disable iff (rst)
    win_valid && win_step == 3'(LAST) && !bc_load |=> !win_valid);
  assert_step_range_R2: assert property (@(posedge clk) disable iff (rst)
    win_valid |-> win_step <= 3'(LAST));
  assert_top_window_zero_R4: assert property (@(posedge clk) disable iff (rst)
    win_valid && win_step == 3'(LAST) |-> win_out[(2*3)*W +: W] == '0);

  for (genvar r = 0; r < NROW; r++) begin : g_edge_chk
    assert_low_edge_zero_R6: assert property (@(posedge clk) disable iff (rst)
      bc_load && border_en && !border_high |=> sr[0][r] == '0);
    assert_high_edge_zero_R7: assert property (@(posedge clk) disable iff (rst)
      bc_load && border_en && border_high |=> sr[NCOL-1][r] == '0);
  end
endmodule

// File: tb/tb_tower_window_shifter.sv
module tb_tower_window_shifter;
  localparam int W = 10, NCOL = 6, NROW = 10, NCORE = 8;

  logic clk = 0, rst = 1, bc_load = 0, border_en = 0, border_high = 0;
  logic [NCOL*NROW*W-1:0] towers_in = '0;
  logic [NCORE*9*W-1:0] win_out;
  logic win_valid;
  logic [2:0] win_step;

  tower_window_shifter #(.W(W), .NCOL(NCOL), .NROW(NROW)) dut (
    .clk(clk), .rst(rst), .bc_load(bc_load), .border_en(border_en),
    .border_high(border_high), .towers_in(towers_in), .win_out(win_out),
    .win_valid(win_valid), .win_step(win_step));

  always #10 clk = ~clk;

  typedef struct {
    bit    valid;
    int    step;
    int    seed;
    bit    zlo, zhi;
    bit    allzero;
    string tag;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int tval(int seed, int t);
    return ((seed * 53 + t * 7) % 1023) + 1;
  endfunction

  function automatic int expw(exp_t e, int c, int r);
    if (e.allzero || c >= NCOL) return 0;
    if (e.zlo && c == 0) return 0;
    if (e.zhi && c == NCOL-1) return 0;
    return tval(e.seed, NROW*c + r);
  endfunction

  task automatic fill(int seed);
    for (int t = 0; t < NCOL*NROW; t++) towers_in[t*W +: W] = W'(tval(seed, t));
  endtask

  task automatic crossing(int seed, bit en, bit hi, int ncyc, string base);
    for (int i = 0; i < ncyc; i++) begin
      exp_t e;
      @(negedge clk);
      bc_load = (i == 0);
      border_en = en;
      border_high = hi;
      if (i == 0) fill(seed); else fill(seed + 77);
      e.valid = 1; e.step = i; e.seed = seed;
      e.zlo = en && !hi; e.zhi = en && hi; e.allzero = 0;
      e.tag = (i == 0) ? {base, "/R2"} : (i == NCOL-2) ? {base, "/R4"} : {base, "/R3"};
      q.push_back(e);
    end
  endtask

  task automatic idle(string tag, bit zero);
    exp_t e;
    @(negedge clk);
    bc_load = 0;
    fill(500);
    e.valid = 0; e.step = 0; e.seed = 0; e.zlo = 0; e.zhi = 0;
    e.allzero = zero; e.tag = tag;
    q.push_back(e);
  endtask

  always @(posedge clk) begin
    #5;
    if (q.size() > 0) begin
      exp_t e;
      bit bad;
      int gk, gl, gd, gv, ev;
      e = q.pop_front();
      bad = 0; gv = 0; ev = 0; gk = 0; gl = 0; gd = 0;
      checks++;
      if (win_valid !== e.valid || (e.valid && win_step !== 3'(e.step))) begin
        fails++;
        $display("FAIL %s: valid/step got %0b/%0d expected %0b/%0d",
                 e.tag, win_valid, win_step, e.valid, e.step);
      end else if (e.valid || e.allzero) begin
        for (int k = 0; k < NCORE; k++)
          for (int l = 0; l < 3; l++)
            for (int d = 0; d < 3; d++) begin
              int got, want;
              got  = int'(win_out[((k*3+l)*3+d)*W +: W]);
              want = expw(e, e.step + l, k + d);
              if (!bad && got != want) begin
                bad = 1; gk = k; gl = l; gd = d; gv = got; ev = want;
              end
            end
        if (bad) begin
          fails++;
          $display("FAIL %s: core %0d loc %0d row+%0d got %0d expected %0d",
                   e.tag, gk, gl, gd, gv, ev);
        end
      end
    end
  end

  initial begin
    #(200000 * 20);
    fails++;
    checks++;
    $display("FAIL watchdog: got hang expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    fill(3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    idle("R1", 1);
    idle("R1", 1);
    crossing(11, 0, 1, 5, "R8");
    idle("R5", 0);
    crossing(22, 1, 0, 5, "R6");
    crossing(33, 1, 1, 5, "R7");
    idle("R5", 0);
    crossing(44, 0, 0, 2, "R9");
    crossing(55, 0, 0, 5, "R9");
    idle("R5", 0);
    idle("R5", 0);
    @(negedge clk);
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule